// File: doc/BRIEF.md
# Real-Time Clock Calendar Counter

This block keeps time of day and calendar date inside a larger chip. A counter of hundredths of a second advances on a time base the host selects. It carries into seconds, minutes and hours, then into day of month, weekday, month and a two-bit year. Leap years are decided by the year count modulo four. Every field is held as packed BCD in a bank of byte registers that the host can read and preset.

Hours run in 24-hour form or in 12-hour form with an AM/PM flag. The time base is either a 32.768 kHz enable pulse, divided down by a fractional accumulator, or a 50 Hz mains enable pulse. A halt bit in the control byte freezes counting. Reads and writes keep working while the block is halted. Byte 07h is a plain storage byte that the counters never touch.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, bytes 00h to 04h and 07h read 00h. Bytes 05h and 06h read 01h, which is date 01, year 0, month 01 and weekday 0.
- R2: With control bit 0 clear, the hundredths field advances on the 328th `osc_tick` after a write to a time register. Exactly 100 advances happen per 32768 `osc_tick` pulses.
- R3: With control bit 0 set, each `mains_tick` pulse adds 2 to the hundredths field, which wraps past 99 (for example 99 becomes 01 with a carry).
- R4: Address map: 01h hundredths, 02h seconds, 03h minutes, 04h hours. A carry out of hundredths steps seconds, 59 seconds carry into minutes, and 59 minutes carry into hours. In 24-hour mode, 23 wraps to 00 and carries into the date.
- R5: Hours byte: bit 7 selects 12-hour mode, bit 6 is the PM flag, and bits 5:0 hold the BCD hour. In 12-hour mode the hour counts 12, 01 and on to 11. Going from 11 to 12 toggles PM, and going from 11 PM to 12 AM carries into the date.
- R6: April, June, September and November have 30 days. February has 29 days when the year is 0 and 28 days otherwise. All other months have 31 days.
- R7: Byte 05h holds the year in bits 7:6 and the BCD date in bits 5:0. Byte 06h holds the weekday (0 to 6) in bits 7:5 and the BCD month in bits 4:0. Weekday 6 wraps to 0, and after December the year steps, with 3 wrapping to 0.
- R8: Control bit 7 at address 00h halts all counting. Host writes still load while the block is halted.
- R9: A host write to any of 01h to 06h loads that byte at once and clears the prescaler. If an advance falls in the same cycle as such a write, the write wins and that advance is dropped.
- R10: `rdata` shows the byte at `addr` one clock after `addr` is presented. Byte 07h reads back what was last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable at 32.768 kHz |
| mains_tick | input | 1 | One-cycle enable at 50 Hz |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |

## Verification
A host preset and a counter advance can land in the same cycle. In that case the preset must win and the whole advance must be dropped, with no field still counting. The bench provokes this by pulsing `mains_tick` and then writing the seconds byte in the very cycle the registered advance reaches the counters. It then reads the bytes back and expects the written seconds together with unchanged hundredths. A second case writes the minutes byte partway through a prescaler cycle. It judges the prescaler clear by the advance arriving a full 328 pulses after that write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int BIN_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HUND  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_YDATE = 3'd5;
  localparam logic [ADDR_W-1:0] A_WMON  = 3'd6;
  localparam logic [ADDR_W-1:0] A_SPARE = 3'd7;

  localparam int CTL_HALT = 7;
  localparam int CTL_BASE = 0;

  function automatic logic [BIN_W-1:0] bcd2bin(input logic [BYTE_W-1:0] b);
    return {3'd0, b[7:4]} * 7'd10 + {3'd0, b[3:0]};
  endfunction

  function automatic logic [BYTE_W-1:0] bin2bcd(input logic [BIN_W-1:0] v);
    logic [BIN_W-1:0] tens, ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [BIN_W-1:0] month_days(input logic [4:0] mon_bcd,
                                                  input logic [1:0] yr);
    case (mon_bcd)
      5'h02:                      return (yr == 2'd0) ? 7'd29 : 7'd28;
      5'h04, 5'h06, 5'h09, 5'h11: return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_pkg::*;
#(
  parameter int OSC_HZ     = 32768,
  parameter int RATE_HZ    = 100,
  parameter int MAINS_STEP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       use_mains,
  input  logic       osc_tick,
  input  logic       mains_tick,
  input  logic       clr,
  output logic       adv,
  output logic [1:0] step
);
  localparam int ACC_W = $clog2(OSC_HZ) + 2;
  localparam logic [ACC_W-1:0] ACC_MOD = ACC_W'(OSC_HZ);
  localparam logic [ACC_W-1:0] ACC_INC = ACC_W'(RATE_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  assign acc_sum = acc_q + ACC_INC;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      adv   <= 1'b0;
      step  <= 2'd1;
    end else begin
      adv <= 1'b0;
      if (run) begin
        if (use_mains) begin
          if (mains_tick) begin
            adv  <= 1'b1;
            step <= 2'(MAINS_STEP);
          end
        end else if (osc_tick) begin
          if (acc_sum >= ACC_MOD) begin
            acc_q <= acc_sum - ACC_MOD;
            adv   <= 1'b1;
            step  <= 2'd1;
          end else begin
            acc_q <= acc_sum;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [1:0]        step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] hund_q,
  output logic [BYTE_W-1:0] sec_q,
  output logic [BYTE_W-1:0] min_q,
  output logic [BYTE_W-1:0] hour_q,
  output logic [BYTE_W-1:0] ydate_q,
  output logic [BYTE_W-1:0] wmon_q
);
  logic [BIN_W-1:0]  h_sum, s_b, m_b, hr_b, dt_b, mo_b, dim;
  logic              c_h, c_s, c_m, c_d, c_mo;
  logic [BYTE_W-1:0] h_nxt, s_nxt, m_nxt, hr_nxt, yd_nxt, wm_nxt, tmp;
  logic [2:0]        wd_nxt;
  logic [4:0]        mo_nxt;
  logic [5:0]        dt_nxt;
  logic [1:0]        yr_nxt;

  always_comb begin
    h_sum = bcd2bin(hund_q) + {5'd0, step};
    c_h   = (h_sum >= 7'd100);
    h_nxt = bin2bcd(c_h ? h_sum - 7'd100 : h_sum);

    s_b   = bcd2bin(sec_q);
    c_s   = c_h && (s_b >= 7'd59);
    s_nxt = !c_h ? sec_q : (c_s ? 8'h00 : bin2bcd(s_b + 7'd1));

    m_b   = bcd2bin(min_q);
    c_m   = c_s && (m_b >= 7'd59);
    m_nxt = !c_s ? min_q : (c_m ? 8'h00 : bin2bcd(m_b + 7'd1));

    hr_b   = bcd2bin({2'b00, hour_q[5:0]});
    tmp    = bin2bcd(hr_b + 7'd1);
    c_d    = 1'b0;
    hr_nxt = hour_q;
    if (c_m) begin
      if (hour_q[7]) begin
        if (hr_b == 7'd11) begin
          hr_nxt = {1'b1, ~hour_q[6], 6'h12};
          c_d    = hour_q[6];
        end else if (hr_b >= 7'd12) begin
          hr_nxt = {1'b1, hour_q[6], 6'h01};
        end else begin
          hr_nxt = {1'b1, hour_q[6], tmp[5:0]};
        end
      end else if (hr_b >= 7'd23) begin
        hr_nxt = 8'h00;
        c_d    = 1'b1;
      end else begin
        hr_nxt = {2'b00, tmp[5:0]};
      end
    end

    dt_b   = bcd2bin({2'b00, ydate_q[5:0]});
    dim    = month_days(wmon_q[4:0], ydate_q[7:6]);
    c_mo   = c_d && (dt_b >= dim);
    tmp    = bin2bcd(dt_b + 7'd1);
    dt_nxt = !c_d ? ydate_q[5:0] : (c_mo ? 6'h01 : tmp[5:0]);
    wd_nxt = !c_d ? wmon_q[7:5] : ((wmon_q[7:5] >= 3'd6) ? 3'd0 : wmon_q[7:5] + 3'd1);

    mo_b   = bcd2bin({3'b000, wmon_q[4:0]});
    tmp    = bin2bcd(mo_b + 7'd1);
    yr_nxt = ydate_q[7:6];
    mo_nxt = wmon_q[4:0];
    if (c_mo) begin
      if (mo_b >= 7'd12) begin
        mo_nxt = 5'h01;
        yr_nxt = ydate_q[7:6] + 2'd1;
      end else begin
        mo_nxt = tmp[4:0];
      end
    end
    yd_nxt = {yr_nxt, dt_nxt};
    wm_nxt = {wd_nxt, mo_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hund_q  <= 8'h00;
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hour_q  <= 8'h00;
      ydate_q <= 8'h01;
      wmon_q  <= 8'h01;
    end else if (wr_en) begin
      case (wr_addr)
        A_HUND:  hund_q  <= wdata;
        A_SEC:   sec_q   <= wdata;
        A_MIN:   min_q   <= wdata;
        A_HOUR:  hour_q  <= wdata;
        A_YDATE: ydate_q <= wdata;
        A_WMON:  wmon_q  <= wdata;
        default: ;
      endcase
    end else if (advance) begin
      hund_q  <= h_nxt;
      sec_q   <= s_nxt;
      min_q   <= m_nxt;
      hour_q  <= hr_nxt;
      ydate_q <= yd_nxt;
      wmon_q  <= wm_nxt;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int OSC_HZ     = 32768,
  parameter int RATE_HZ    = 100,
  parameter int MAINS_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              mains_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] ctrl_q, spare_q;
  logic [BYTE_W-1:0] hund_q, sec_q, min_q, hour_q, ydate_q, wmon_q;
  logic              time_wr, adv, halt, chain_wr;
  logic [1:0]        step;

  assign halt     = ctrl_q[CTL_HALT];
  assign time_wr  = wr_en && (addr inside {A_HUND, A_SEC, A_MIN, A_HOUR, A_YDATE, A_WMON});
  assign chain_wr = time_wr;

  rtc_tick_gen #(
    .OSC_HZ(OSC_HZ), .RATE_HZ(RATE_HZ), .MAINS_STEP(MAINS_STEP)
  ) u_tick (
    .clk(clk), .rst(rst), .run(!halt), .use_mains(ctrl_q[CTL_BASE]),
    .osc_tick(osc_tick), .mains_tick(mains_tick), .clr(time_wr),
    .adv(adv), .step(step)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst(rst), .advance(adv && !halt), .step(step),
    .wr_en(chain_wr), .wr_addr(addr), .wdata(wdata),
    .hund_q(hund_q), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
    .ydate_q(ydate_q), .wmon_q(wmon_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      spare_q <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL)  ctrl_q  <= wdata;
      if (addr == A_SPARE) spare_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:  rdata <= ctrl_q;
        A_HUND:  rdata <= hund_q;
        A_SEC:   rdata <= sec_q;
        A_MIN:   rdata <= min_q;
        A_HOUR:  rdata <= hour_q;
        A_YDATE: rdata <= ydate_q;
        A_WMON:  rdata <= wmon_q;
        default: rdata <= spare_q;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] ctrl,
  input logic [7:0] hund,
  input logic [7:0] sec,
  input logic [7:0] hour,
  input logic [7:0] ydate,
  input logic [7:0] wmon
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ctrl[7] && !wr_en) |=> $stable(hund)); // R8

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2) |=> (sec == $past(wdata))); // R9

  AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(sec) || $past(hund) >= 8'h98)); // R4

  AST_PM_ON_ELEVEN: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(hour[6]) || $past(hour[5:0]) == 6'h11)); // R5

  AST_YEAR_ON_DEC: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ydate[7:6]) || $past(wmon[4:0]) == 5'h12)); // R7
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl(ctrl_q), .hund(hund_q), .sec(sec_q), .hour(hour_q),
  .ydate(ydate_q), .wmon(wmon_q)
);

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       mains_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  rtc_calendar_core uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .mains_tick(mains_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // {hund, sec, min, hour, ydate, wmon, exp hund, sec, min, hour, ydate, wmon}
  localparam logic [95:0] VEC [0:7] = '{
    96'h98_59_59_23_28_C2_00_00_00_00_29_02,
    96'h98_59_59_23_68_C2_00_00_00_00_41_03,
    96'h98_59_59_23_F1_52_00_00_00_00_01_61,
    96'h98_59_59_91_15_25_00_00_00_D2_15_25,
    96'h98_59_59_D1_30_24_00_00_00_92_01_45,
    96'h98_59_59_92_15_25_00_00_00_81_15_25,
    96'h37_10_05_08_15_25_39_10_05_08_15_25,
    96'h99_45_05_08_15_25_01_46_05_08_15_25
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:    return "R6 leap/Feb";
      2:       return "R7 year wrap";
      3, 4, 5: return "R5 12h";
      default: return "R3 mains step";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic mains_pulse();
    @(negedge clk); mains_tick = 1'b1;
    @(negedge clk); mains_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic osc_run(input int n);
    @(negedge clk); osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), got);
      check("R1 reset", got, (a == 5 || a == 6) ? 8'h01 : 8'h00);
    end
    // R10 spare byte and control readback
    wr(3'd7, 8'hA5);
    rd(3'd7, got); check("R10 spare", got, 8'hA5);
    wr(3'd0, 8'h01);
    rd(3'd0, got); check("R10 ctrl", got, 8'h01);

    // vector table in mains mode: R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      for (int f = 0; f < 6; f++) wr(3'(f + 1), VEC[v][95 - 8*f -: 8]);
      mains_pulse();
      for (int f = 0; f < 6; f++) begin
        rd(3'(f + 1), got);
        check(vec_tag(v), got, VEC[v][47 - 8*f -: 8]);
      end
    end

    // R8 halt freezes, writes still load
    wr(3'd0, 8'h81);
    wr(3'd1, 8'h20);
    mains_pulse();
    rd(3'd1, got); check("R8 halted", got, 8'h20);
    wr(3'd0, 8'h01);
    mains_pulse();
    rd(3'd1, got); check("R3 resumed", got, 8'h22);

    // R9 collision: write seconds in the cycle the advance lands
    wr(3'd1, 8'h10);
    @(negedge clk); mains_tick = 1'b1;
    @(negedge clk); mains_tick = 1'b0; wr_en = 1'b1; addr = 3'd2; wdata = 8'h20;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd1, got); check("R9 collide hund", got, 8'h10);
    rd(3'd2, got); check("R9 collide sec", got, 8'h20);

    // R2 crystal path
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    osc_run(327);
    rd(3'd1, got); check("R2 before 328", got, 8'h00);
    osc_run(1);
    rd(3'd1, got); check("R2 at 328", got, 8'h01);
    osc_run(32768 - 328);
    rd(3'd1, got); check("R2 full hund", got, 8'h00);
    rd(3'd2, got); check("R2 full sec", got, 8'h01);

    // R9 prescaler clear on write
    wr(3'd1, 8'h00);
    osc_run(200);
    wr(3'd3, 8'h07);
    osc_run(327);
    rd(3'd1, got); check("R9 prescaler clear", got, 8'h00);
    osc_run(1);
    rd(3'd1, got); check("R9 after clear", got, 8'h01);
    rd(3'd3, got); check("R9 min load", got, 8'h07);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule